// File: doc/BRIEF.md
# Microwire EEPROM Read Controller

This block reads 16-bit words out of a three-wire serial configuration EEPROM (chip select, shift clock, serial data towards the memory, serial data back from it). Every clock phase is paced by an external bit-rate tick, so the serial rate is set by whoever generates the tick and not by the block.

After reset the block works on its own. It first reads word 0 using 8-bit addressing. If that word carries the signature 0x8129, the device is taken to use 8-bit addresses; otherwise it uses 6-bit addresses. With that width it reads words 7, 8 and 9 and assembles them into a 48-bit station address. It then raises a one-cycle completion pulse and a sticky valid flag.

From then on a valid/ready request port accepts single-word reads and returns each result on a valid/ready response port. A request is accepted only on a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low during the start-up load, while a transfer is on the wire, and while a response is waiting. The response is held until `rsp_ready` takes it. Because of this, back-pressure on the response port stalls the request port.

Top module: `mwire_rom_reader`

## Requirements
- R1: Every read command is shifted out MSB first as the three bits 1, 1, 0 (start bit plus read opcode, value 6), followed by the word address MSB first.
- R2: A read puts 9 clock rises on the shift clock for the command with 6-bit addressing and 11 with 8-bit addressing, then 16 more for the data, so a transfer has 25 or 27 rises.
- R3: Serial data towards the memory changes only while the shift clock is low. It never changes while the clock stays high.
- R4: Chip select rises before the first shift clock and falls after the last data bit. The shift clock is never high while chip select is low.
- R5: The 16 returned data bits are taken MSB first, one per high clock phase, and `rsp_data` equals the word stored at the addressed location.
- R6: `addr_wide` becomes 1 when word 0, read with 8-bit addressing, equals 0x8129, and 0 for any other value.
- R7: `station_addr` is {word 9, word 8, word 7}. Byte 0 of the address sits in bits [7:0] and is the low byte of word 7 (little-endian words).
- R8: Completion of the start-up load gives a one-cycle `boot_done` pulse, in the same cycle that `station_valid` rises. `station_valid` then stays high until reset.
- R9: `req_ready` is low until the start-up load is complete. A request offered and withdrawn during that time causes no transfer and no response.
- R10: Once raised, `rsp_valid` stays high with stable `rsp_data` until a cycle where `rsp_ready` is high. `req_ready` is low while it waits.
- R11: The shift clock changes level only on a clock edge that follows a cycle in which `tick` was high, so every clock phase lasts at least one tick.
- R12: With 6-bit addressing only the low 6 bits of `req_addr` are sent. With 8-bit addressing all 8 bits are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-rate tick; each serial clock phase advances on it |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 8 | Word address of the request |
| rsp_valid | output | 1 | Read result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 16 | Word read from the memory |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory shift clock |
| ee_di | output | 1 | Serial data towards the memory |
| ee_do | input | 1 | Serial data from the memory |
| station_addr | output | 48 | Station address assembled at start-up |
| station_valid | output | 1 | Station address loaded |
| boot_done | output | 1 | One-cycle pulse when the start-up load ends |
| addr_wide | output | 1 | 1 = 8-bit addressing detected, 0 = 6-bit |

## Verification
The bench attaches a serial memory model that captures every command bit. The block is run against two memories: one that carries the signature and one that does not. Comparing the two shows whether the width decision, the command length and the masking of the address follow the signature.

A table of request addresses is walked in both cases. It contains all-zero, all-ones, values just below and above 64, and the station-address words. These addresses separate MSB-first from LSB-first shifting, show whether the two top address bits are dropped in narrow mode, and show whether the data comes back in the right bit order.

Two directed tests cover the request port. In one, the response consumer is stalled, which shows whether the response is held and the request port blocked. In the other, a request is offered and withdrawn during the start-up load, which shows whether it is really left unserved.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  // Command opcodes including the leading start bit
  localparam logic [2:0] OP_READ  = 3'b110;
  localparam logic [2:0] OP_WRITE = 3'b101;
  localparam logic [2:0] OP_ERASE = 3'b111;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD_LO, PH_CMD_HI, PH_DAT_LO, PH_DAT_HI, PH_FIN
  } phase_t;

  typedef enum logic [1:0] {
    BT_ISSUE, BT_WAIT, BT_RUN
  } boot_t;
endpackage

// File: rtl/mwr_engine.sv
module mwr_engine
  import mwr_pkg::*;
#(
  parameter int AW_N = 6,
  parameter int AW_W = 8,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            start,
  input  logic            wide,
  input  logic [AW_W-1:0] addr,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic            cs,
  output logic            sk,
  output logic            di,
  input  logic            do_i
);
  localparam int CMD_W = 3 + AW_W;
  localparam int PAD   = AW_W - AW_N;
  localparam int CNT_W = $clog2(CMD_W + DW);

  phase_t           ph;
  logic [CMD_W-1:0] shreg;
  logic [CMD_W-1:0] load_w;
  logic [CNT_W-1:0] cnt;

  // Narrow commands are left-aligned so the MSB always leaves first
  always_comb begin
    if (wide) load_w = {OP_READ, addr};
    else      load_w = {OP_READ, addr[AW_N-1:0], {PAD{1'b0}}};
  end

  assign busy = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      shreg <= '0;
      cnt   <= '0;
      rdata <= '0;
      cs    <= 1'b0;
      sk    <= 1'b0;
      di    <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          cs    <= 1'b1;
          sk    <= 1'b0;
          shreg <= load_w;
          di    <= load_w[CMD_W-1];
          cnt   <= wide ? CNT_W'(CMD_W - 1) : CNT_W'(AW_N + 2);
          ph    <= PH_CMD_LO;
        end
        PH_CMD_LO: if (tick) begin
          sk <= 1'b1;
          ph <= PH_CMD_HI;
        end
        PH_CMD_HI: if (tick) begin
          sk <= 1'b0;
          if (cnt == '0) begin
            di  <= 1'b0;
            cnt <= CNT_W'(DW - 1);
            ph  <= PH_DAT_LO;
          end else begin
            shreg <= {shreg[CMD_W-2:0], 1'b0};
            di    <= shreg[CMD_W-2];
            cnt   <= cnt - 1'b1;
            ph    <= PH_CMD_LO;
          end
        end
        PH_DAT_LO: if (tick) begin
          sk <= 1'b1;
          ph <= PH_DAT_HI;
        end
        PH_DAT_HI: if (tick) begin
          rdata <= {rdata[DW-2:0], do_i};
          sk    <= 1'b0;
          if (cnt == '0) ph <= PH_FIN;
          else begin
            cnt <= cnt - 1'b1;
            ph  <= PH_DAT_LO;
          end
        end
        PH_FIN: if (tick) begin
          cs   <= 1'b0;
          done <= 1'b1;
          ph   <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwr_ctrl.sv
module mwr_ctrl
  import mwr_pkg::*;
#(
  parameter int            AW_W      = 8,
  parameter int            DW        = 16,
  parameter int            MAC_WORDS = 3,
  parameter int            MAC_BASE  = 7,
  parameter logic [DW-1:0] SIG       = 16'h8129
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [AW_W-1:0]       req_addr,
  output logic                  req_ready,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DW-1:0]         rsp_data,
  output logic                  eng_start,
  output logic                  eng_wide,
  output logic [AW_W-1:0]       eng_addr,
  input  logic                  eng_done,
  input  logic [DW-1:0]         eng_rdata,
  output logic [DW*MAC_WORDS-1:0] mac,
  output logic                  mac_valid,
  output logic                  boot_done,
  output logic                  wide
);
  localparam int STEP_W = $clog2(MAC_WORDS + 1);

  boot_t             st;
  logic [STEP_W-1:0] step;
  logic              inflight;
  logic [DW-1:0]     mac_w [MAC_WORDS];

  assign wide      = mac_valid ? eng_wide : 1'b0;
  assign req_ready = (st == BT_RUN) && !inflight && !rsp_valid;
  assign eng_start = (st == BT_ISSUE) || (req_valid && req_ready);

  logic wide_q;
  always_comb begin
    eng_wide = (st != BT_RUN && step == '0) ? 1'b1 : wide_q;
    if (st == BT_RUN)     eng_addr = req_addr;
    else if (step == '0)  eng_addr = '0;
    else                  eng_addr = AW_W'(MAC_BASE) + AW_W'(step) - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= BT_ISSUE;
      step      <= '0;
      wide_q    <= 1'b0;
      inflight  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      mac_valid <= 1'b0;
      boot_done <= 1'b0;
    end else begin
      boot_done <= 1'b0;
      case (st)
        BT_ISSUE: st <= BT_WAIT;
        BT_WAIT: if (eng_done) begin
          if (step == '0) wide_q <= (eng_rdata == SIG);
          if (step == STEP_W'(MAC_WORDS)) begin
            st        <= BT_RUN;
            mac_valid <= 1'b1;
            boot_done <= 1'b1;
          end else begin
            step <= step + 1'b1;
            st   <= BT_ISSUE;
          end
        end
        BT_RUN: begin
          if (req_valid && req_ready) inflight <= 1'b1;
          if (eng_done && inflight) begin
            inflight  <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_data  <= eng_rdata;
          end else if (rsp_valid && rsp_ready) begin
            rsp_valid <= 1'b0;
          end
        end
        default: st <= BT_ISSUE;
      endcase
    end
  end

  // One capture register per station-address word, lowest word lowest
  for (genvar g = 0; g < MAC_WORDS; g++) begin : g_mac
    always_ff @(posedge clk) begin
      if (!rst_n) mac_w[g] <= '0;
      else if (st == BT_WAIT && eng_done && step == STEP_W'(g + 1))
        mac_w[g] <= eng_rdata;
    end
    assign mac[g*DW +: DW] = mac_w[g];
  end
endmodule

// File: rtl/mwire_rom_reader.sv
module mwire_rom_reader #(
  parameter int AW_N      = 6,
  parameter int AW_W      = 8,
  parameter int DW        = 16,
  parameter int MAC_WORDS = 3,
  parameter int MAC_BASE  = 7,
  parameter logic [15:0] SIG = 16'h8129
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW_W-1:0]         req_addr,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DW-1:0]           rsp_data,
  output logic                    ee_cs,
  output logic                    ee_sk,
  output logic                    ee_di,
  input  logic                    ee_do,
  output logic [DW*MAC_WORDS-1:0] station_addr,
  output logic                    station_valid,
  output logic                    boot_done,
  output logic                    addr_wide
);
  logic            eng_start;
  logic            eng_wide;
  logic [AW_W-1:0] eng_addr;
  logic            eng_busy;
  logic            eng_done;
  logic [DW-1:0]   eng_rdata;

  mwr_ctrl #(
    .AW_W(AW_W), .DW(DW), .MAC_WORDS(MAC_WORDS), .MAC_BASE(MAC_BASE), .SIG(SIG)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .eng_start (eng_start),
    .eng_wide  (eng_wide),
    .eng_addr  (eng_addr),
    .eng_done  (eng_done),
    .eng_rdata (eng_rdata),
    .mac       (station_addr),
    .mac_valid (station_valid),
    .boot_done (boot_done),
    .wide      (addr_wide)
  );

  mwr_engine #(.AW_N(AW_N), .AW_W(AW_W), .DW(DW)) u_eng (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .start (eng_start),
    .wide  (eng_wide),
    .addr  (eng_addr),
    .busy  (eng_busy),
    .done  (eng_done),
    .rdata (eng_rdata),
    .cs    (ee_cs),
    .sk    (ee_sk),
    .di    (ee_di),
    .do_i  (ee_do)
  );

  logic unused_busy;
  assign unused_busy = eng_busy;
endmodule

// File: rtl/mwr_checker.sv
module mwr_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          ee_cs,
  input logic          ee_sk,
  input logic          ee_di,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          station_valid,
  input logic          boot_done
);
  a_r4_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);

  a_r3_di_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  a_r11_sk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk != $past(ee_sk)) |-> $past(tick));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r10_block_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r9_no_ready_boot: assert property (@(posedge clk) disable iff (!rst_n)
    !station_valid |-> !req_ready);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done);

  a_r8_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> (station_valid && !$past(station_valid)));

  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    station_valid |=> station_valid);
endmodule

bind mwire_rom_reader mwr_checker #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .ee_cs         (ee_cs),
  .ee_sk         (ee_sk),
  .ee_di         (ee_di),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .station_valid (station_valid),
  .boot_done     (boot_done)
);

// File: tb/mwire_rom_reader_tb.sv
module mwire_rom_reader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;
  logic [47:0] station_addr;
  logic        station_valid, boot_done, addr_wide;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;

  always #4 clk = ~clk;

  int unsigned tdiv = 0;
  always @(posedge clk) begin
    tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
    tick <= (tdiv == 2);
  end

  mwire_rom_reader u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .station_addr(station_addr), .station_valid(station_valid),
    .boot_done(boot_done), .addr_wide(addr_wide)
  );

  // ---------------- serial memory model ----------------
  logic        chip8 = 1'b1;
  int unsigned rises = 0;
  int unsigned xfers = 0;
  int unsigned cmd_len = 11;
  int unsigned last_rises = 0;
  logic [10:0] capt = '0;
  logic [2:0]  last_op = '0;
  logic [7:0]  last_addr = '0;
  logic [15:0] word_out = '0;

  function automatic logic [15:0] rom(input logic [7:0] i);
    if (i == 8'd0) return chip8 ? 16'h8129 : 16'h1C2E;
    return 16'hC3A5 ^ {i, ~i};
  endfunction

  function automatic logic [7:0] cmd_addr();
    return (cmd_len == 11) ? capt[7:0] : {2'b00, capt[5:0]};
  endfunction

  always @(posedge ee_cs) begin
    rises   = 0;
    capt    = '0;
    cmd_len = (chip8 || xfers == 0) ? 11 : 9;
  end

  always @(posedge ee_sk) if (ee_cs) begin
    if (rises < cmd_len) begin
      capt = {capt[9:0], ee_di};
      if (rises == cmd_len - 1)
        word_out = rom(cmd_addr() & (chip8 ? 8'hFF : 8'h3F));
    end else begin
      ee_do    = word_out[15];
      word_out = {word_out[14:0], 1'b0};
    end
    rises++;
  end

  always @(negedge ee_cs) if (rises > 0) begin
    last_rises = rises;
    last_op    = (cmd_len == 11) ? capt[10:8] : capt[8:6];
    last_addr  = cmd_addr();
    xfers++;
    ee_do      = 1'b0;
  end

  // ---------------- checking helpers ----------------
  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    xfers = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_boot(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (boot_done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic read_word(input logic [7:0] a, output logic [15:0] d, output bit ok);
    ok = 1'b0;
    d  = '0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    for (int k = 0; k < 5000; k++) begin
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      if (rsp_valid) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    d = rsp_data;
    @(negedge clk);
  endtask

  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{8'h00, 8'h05, 8'h3F, 8'h40, 8'h7A, 8'hFF, 8'h09, 8'hA2};

  task automatic walk_vectors();
    logic [7:0] m;
    m = chip8 ? 8'hFF : 8'h3F;
    for (int v = 0; v < NV; v++) begin
      logic [15:0] d;
      bit ok;
      read_word(VEC[v], d, ok);
      check("R5 response arrives", 64'(ok), 64'd1);
      check("R5 data", 64'(d), 64'(rom(VEC[v] & m)));
      check("R1 opcode bits", 64'(last_op), 64'd6);
      check("R12 sent address", 64'(last_addr), 64'(VEC[v] & m));
      check("R2 clock rises", 64'(last_rises), chip8 ? 64'd27 : 64'd25);
    end
  endtask

  task automatic boot_checks();
    bit ok;
    wait_boot(ok);
    check("R8 boot pulse seen", 64'(ok), 64'd1);
    check("R8 valid with pulse", 64'(station_valid), 64'd1);
    check("R6 width flag", 64'(addr_wide), 64'(chip8));
    check("R7 station address", 64'(station_addr), 64'({rom(8'd9), rom(8'd8), rom(8'd7)}));
    check("R2 boot transfers", 64'(xfers), 64'd4);
    check("R2 last boot rises", 64'(last_rises), chip8 ? 64'd27 : 64'd25);
    check("R12 last boot address", 64'(last_addr), 64'd9);
    @(negedge clk);
    check("R8 pulse one cycle", 64'(boot_done), 64'd0);
    check("R8 valid sticky", 64'(station_valid), 64'd1);
  endtask

  initial begin
    logic [15:0] d;
    bit ok;
    logic [15:0] held;

    // Reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 cs low in reset", 64'(ee_cs), 64'd0);
    check("R4 sk low in reset", 64'(ee_sk), 64'd0);
    check("R9 not ready in reset", 64'(req_ready), 64'd0);
    check("R10 no response in reset", 64'(rsp_valid), 64'd0);
    check("R8 no station in reset", 64'(station_valid), 64'd0);

    // Wide memory with the signature; request offered and withdrawn during boot
    chip8 = 1'b1;
    do_reset();
    repeat (10) @(negedge clk);
    check("R9 not ready while loading", 64'(req_ready), 64'd0);
    req_valid = 1'b1;
    req_addr  = 8'h22;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    boot_checks();
    repeat (300) @(negedge clk);
    check("R9 withdrawn request no response", 64'(rsp_valid), 64'd0);
    check("R9 withdrawn request no transfer", 64'(xfers), 64'd4);
    walk_vectors();

    // Response back-pressure
    rsp_ready = 1'b0;
    read_word(8'h33, d, ok);
    held = d;
    repeat (40) @(negedge clk);
    check("R10 response held", 64'(rsp_valid), 64'd1);
    check("R10 data stable", 64'(rsp_data), 64'(held));
    check("R10 request blocked", 64'(req_ready), 64'd0);
    check("R10 held data value", 64'(held), 64'(rom(8'h33)));
    rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 released", 64'(rsp_valid), 64'd0);
    check("R10 ready again", 64'(req_ready), 64'd1);

    // Narrow memory without the signature
    chip8 = 1'b0;
    do_reset();
    boot_checks();
    walk_vectors();

    finish_run();
  end
endmodule